// File: doc/BRIEF.md
# Serial Flash Status Register Engine

This block is the slave-side front end of a serial NOR flash that owns the status byte. It watches the serial clock, select and data-in lines, frames the bytes that arrive while the device is selected, and decodes each framed byte as a command. The commands it handles set or clear the write-enable latch, read the status byte, write the status byte, switch the device into four-byte addressing, and run a two-step software reset. The write-enable latch, the protect field and the four-byte flag go out as plain outputs to the program and erase logic of the device.

The serial lines and the write-protect pin are asynchronous to the block's own clock. They pass through a synchronizer, and SCK edges are found by comparing successive synchronized samples. The block works in SPI mode 0: data-in is taken on rising SCK, and data-out changes after falling SCK. A status write is gated twice. The write-enable latch must be set, and the pin-level hardware protection must not be in force. Hardware protection is in force when the write-protect pin is low and the lock bit (status bit 7) is already set. A pulse from the program/erase logic marks the end of an operation and clears the latch.

Top module: `flash_status_regs`

## Requirements
- R1: After power-on reset the write-enable latch, the lock bit, the protect field and the four-byte flag are all 0, and MISO is 0.
- R2: Opcode 0x06 sets the write-enable latch. Opcode 0x04 clears it.
- R3: After opcode 0x05, each following byte of the same select window returns the current status byte on MISO, most significant bit first, with each bit changed after a falling SCK. The status layout is: bit 7 lock, bits 6..2 protect field (field bit 0 at status bit 2), bit 1 write-enable latch, bit 0 reads 0. While the device is deselected MISO is 0.
- R4: Opcode 0x01 followed by a data byte, with the latch set and no hardware protection, copies data bit 7 into the lock bit and data bits 6..2 into the protect field, and clears the latch.
- R5: A status write issued while the latch is clear changes neither the lock bit nor the protect field.
- R6: A status write is refused when the write-protect pin is low and the lock bit is 1. Lock and protect stay unchanged, and the latch stays set. With the pin high, or with the lock bit 0, the write is accepted.
- R7: Opcode 0xB7 sets the four-byte address flag.
- R8: Opcode 0x66 immediately followed by opcode 0x99 clears the latch and the four-byte flag and keeps the lock bit and the protect field. A 0x99 that does not directly follow 0x66 has no effect.
- R9: Several commands may follow one another in one select window, and each is decoded in turn.
- R10: A pulse on `op_done` clears the latch. If it lands in the same cycle as a completed 0x06 opcode, the latch ends up set.
- R11: Raising select in the middle of a byte discards the partial bits, and the next window frames its first byte from a fresh start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low power-on reset |
| spi_sck | input | 1 | Serial clock from the host |
| spi_cs_n | input | 1 | Active-low device select |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| wp_n | input | 1 | Active-low hardware write-protect pin |
| op_done | input | 1 | Single-cycle pulse from the program/erase logic marking an operation's end |
| wel | output | 1 | Write-enable latch |
| srwd | output | 1 | Status lock bit |
| prot | output | PROT_BITS | Block-protect field |
| addr4 | output | 1 | Four-byte address mode flag |

## Verification
The completion of a write-enable opcode and an `op_done` pulse can both act on the latch in the same clock cycle. The bench counts the synchronizer and edge-detect stages between a rising SCK and the controller's update, then raises `op_done` on exactly the cycle when the eighth rising edge of a 0x06 byte is decoded. The result is judged at the `wel` port and must be set. A lone `op_done` pulse, outside any command, is checked separately and must clear the latch.

// File: rtl/flash_status_pkg.sv
package flash_status_pkg;
   localparam int BYTE_W = 8;

   localparam logic [BYTE_W-1:0] OPC_WR_ENABLE  = 8'h06;
   localparam logic [BYTE_W-1:0] OPC_WR_DISABLE = 8'h04;
   localparam logic [BYTE_W-1:0] OPC_RD_STATUS  = 8'h05;
   localparam logic [BYTE_W-1:0] OPC_WR_STATUS  = 8'h01;
   localparam logic [BYTE_W-1:0] OPC_ADDR4_ON   = 8'hB7;
   localparam logic [BYTE_W-1:0] OPC_RST_ARM    = 8'h66;
   localparam logic [BYTE_W-1:0] OPC_RST_FIRE   = 8'h99;

   typedef enum logic [1:0] {
      PH_OPCODE = 2'd0,
      PH_WDATA  = 2'd1,
      PH_RDOUT  = 2'd2
   } phase_t;
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sck_i,
   input  logic cs_n_i,
   input  logic mosi_i,
   input  logic wp_n_i,
   output logic desel_o,
   output logic mosi_o,
   output logic wp_n_o,
   output logic sck_rise_o,
   output logic sck_fall_o
);
   localparam int LINES = 4;
   localparam logic [LINES-1:0] RST_VAL = 4'b1010; // wp_n=1, mosi=0, cs_n=1, sck=0

   logic [LINES-1:0] pipe [STAGES];
   logic             sck_last;

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) pipe[s] <= RST_VAL;
               else        pipe[s] <= {wp_n_i, mosi_i, cs_n_i, sck_i};
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) pipe[s] <= RST_VAL;
               else        pipe[s] <= pipe[s-1];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) sck_last <= 1'b0;
      else        sck_last <= pipe[STAGES-1][0];

   assign desel_o    = pipe[STAGES-1][1];
   assign mosi_o     = pipe[STAGES-1][2];
   assign wp_n_o     = pipe[STAGES-1][3];
   assign sck_rise_o = pipe[STAGES-1][0] & ~sck_last;
   assign sck_fall_o = ~pipe[STAGES-1][0] & sck_last;
endmodule

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter
   import flash_status_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              desel,
   input  logic              sck_rise,
   input  logic              sck_fall,
   input  logic              mosi,
   input  logic              tx_load,
   input  logic [BYTE_W-1:0] tx_byte,
   output logic              byte_done,
   output logic [BYTE_W-1:0] rx_byte,
   output logic              miso
);
   localparam int CNT_W = $clog2(BYTE_W);

   logic [CNT_W-1:0]  bit_cnt;
   logic [BYTE_W-1:0] rx_sh;
   logic [BYTE_W-1:0] tx_sh;

   assign byte_done = ~desel & sck_rise & (bit_cnt == CNT_W'(BYTE_W-1));
   assign rx_byte   = {rx_sh[BYTE_W-2:0], mosi};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt <= '0;
         rx_sh   <= '0;
         tx_sh   <= '0;
         miso    <= 1'b0;
      end else if (desel) begin
         bit_cnt <= '0;
         tx_sh   <= '0;
         miso    <= 1'b0;
      end else begin
         if (sck_rise) begin
            rx_sh   <= rx_byte;
            bit_cnt <= bit_cnt + 1'b1;
         end
         if (tx_load) begin
            tx_sh <= tx_byte;
         end else if (sck_fall) begin
            miso  <= tx_sh[BYTE_W-1];
            tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
         end
      end
   end

   assert_idle_miso_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      desel |=> (miso == 1'b0));

   assert_fresh_frame_R11 : assert property (@(posedge clk) disable iff (!rst_n)
      desel |=> !byte_done);
endmodule

// File: rtl/status_cmd_ctrl.sv
module status_cmd_ctrl
   import flash_status_pkg::*;
#(
   parameter int PROT_BITS = 5
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 desel,
   input  logic                 wp_n,
   input  logic                 op_done,
   input  logic                 byte_done,
   input  logic [BYTE_W-1:0]    rx_byte,
   output logic                 tx_load,
   output logic [BYTE_W-1:0]    status,
   output logic                 wel_q,
   output logic                 srwd_q,
   output logic [PROT_BITS-1:0] prot_q,
   output logic                 addr4_q
);
   localparam int PROT_LSB = 2;
   localparam int PROT_MAX = BYTE_W - 1 - PROT_LSB;

   phase_t               phase_q, phase_d;
   logic                 armed_q, armed_d;
   logic                 wel_d, srwd_d, addr4_d;
   logic [PROT_BITS-1:0] prot_d;
   logic                 hw_locked;
   logic                 opc_seen;

   assign hw_locked = ~wp_n & srwd_q;
   assign opc_seen  = byte_done & (phase_q == PH_OPCODE);

   assign status[BYTE_W-1] = srwd_q;
   assign status[1]        = wel_q;
   assign status[0]        = 1'b0;
   generate
      for (genvar i = 0; i < PROT_MAX; i++) begin : g_stat
         if (i < PROT_BITS) begin : g_used
            assign status[PROT_LSB+i] = prot_q[i];
         end else begin : g_zero
            assign status[PROT_LSB+i] = 1'b0;
         end
      end
   endgenerate

   assign tx_load = byte_done &
                    ((phase_q == PH_RDOUT) || (opc_seen && rx_byte == OPC_RD_STATUS));

   always_comb begin
      phase_d = phase_q;
      armed_d = armed_q;
      wel_d   = wel_q;
      srwd_d  = srwd_q;
      prot_d  = prot_q;
      addr4_d = addr4_q;
      if (op_done) wel_d = 1'b0;
      if (desel) begin
         phase_d = PH_OPCODE;
      end else if (byte_done) begin
         unique case (phase_q)
            PH_OPCODE: begin
               armed_d = (rx_byte == OPC_RST_ARM);
               unique case (rx_byte)
                  OPC_WR_ENABLE:  wel_d   = 1'b1;
                  OPC_WR_DISABLE: wel_d   = 1'b0;
                  OPC_RD_STATUS:  phase_d = PH_RDOUT;
                  OPC_WR_STATUS:  phase_d = PH_WDATA;
                  OPC_ADDR4_ON:   addr4_d = 1'b1;
                  OPC_RST_FIRE: begin
                     if (armed_q) begin
                        wel_d   = 1'b0;
                        addr4_d = 1'b0;
                     end
                  end
                  default: ;
               endcase
            end
            PH_WDATA: begin
               phase_d = PH_OPCODE;
               if (wel_q && !hw_locked) begin
                  srwd_d = rx_byte[BYTE_W-1];
                  prot_d = rx_byte[PROT_LSB +: PROT_BITS];
                  wel_d  = 1'b0;
               end
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_OPCODE;
         armed_q <= 1'b0;
         wel_q   <= 1'b0;
         srwd_q  <= 1'b0;
         prot_q  <= '0;
         addr4_q <= 1'b0;
      end else begin
         phase_q <= phase_d;
         armed_q <= armed_d;
         wel_q   <= wel_d;
         srwd_q  <= srwd_d;
         prot_q  <= prot_d;
         addr4_q <= addr4_d;
      end
   end

   assert_wren_sets_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      (!desel && opc_seen && rx_byte == OPC_WR_ENABLE) |=> wel_q);

   assert_no_wel_no_write_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      (!desel && byte_done && phase_q == PH_WDATA && !wel_q)
      |=> ($stable(srwd_q) && $stable(prot_q)));

   assert_hw_lock_holds_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      (!wp_n && srwd_q) |=> srwd_q);

   assert_addr4_set_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      (!desel && opc_seen && rx_byte == OPC_ADDR4_ON) |=> addr4_q);

   assert_done_clears_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      (op_done && !(!desel && opc_seen && rx_byte == OPC_WR_ENABLE)) |=> !wel_q);
endmodule

// File: rtl/flash_status_regs.sv
module flash_status_regs
   import flash_status_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int PROT_BITS   = 5
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 spi_sck,
   input  logic                 spi_cs_n,
   input  logic                 spi_mosi,
   output logic                 spi_miso,
   input  logic                 wp_n,
   input  logic                 op_done,
   output logic                 wel,
   output logic                 srwd,
   output logic [PROT_BITS-1:0] prot,
   output logic                 addr4
);
   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (PROT_BITS < 1 || PROT_BITS > BYTE_W - 3) begin : g_bad_prot
         $error("PROT_BITS must lie between 1 and 5");
      end
   endgenerate

   logic              desel, mosi_s, wp_n_s, rise, fall;
   logic              byte_done, tx_load;
   logic [BYTE_W-1:0] rx_byte, status;

   spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk        (clk),
      .rst_n      (rst_n),
      .sck_i      (spi_sck),
      .cs_n_i     (spi_cs_n),
      .mosi_i     (spi_mosi),
      .wp_n_i     (wp_n),
      .desel_o    (desel),
      .mosi_o     (mosi_s),
      .wp_n_o     (wp_n_s),
      .sck_rise_o (rise),
      .sck_fall_o (fall)
   );

   spi_byte_shifter u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .desel     (desel),
      .sck_rise  (rise),
      .sck_fall  (fall),
      .mosi      (mosi_s),
      .tx_load   (tx_load),
      .tx_byte   (status),
      .byte_done (byte_done),
      .rx_byte   (rx_byte),
      .miso      (spi_miso)
   );

   status_cmd_ctrl #(.PROT_BITS(PROT_BITS)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .desel     (desel),
      .wp_n      (wp_n_s),
      .op_done   (op_done),
      .byte_done (byte_done),
      .rx_byte   (rx_byte),
      .tx_load   (tx_load),
      .status    (status),
      .wel_q     (wel),
      .srwd_q    (srwd),
      .prot_q    (prot),
      .addr4_q   (addr4)
   );
endmodule

// File: tb/flash_status_regs_test.sv
module flash_status_regs_test;
   localparam int HALF = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sck = 1'b0, cs_n = 1'b1, mosi = 1'b0, wp_n = 1'b1, op_done = 1'b0;
   logic       miso, wel, srwd, addr4;
   logic [4:0] prot;
   int         checks = 0, failures = 0;
   logic [7:0] rd;

   always #2 clk = ~clk;

   flash_status_regs uut (
      .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi),
      .spi_miso(miso), .wp_n(wp_n), .op_done(op_done), .wel(wel), .srwd(srwd),
      .prot(prot), .addr4(addr4)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic waitn(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic sel();
      @(negedge clk); cs_n = 1'b0; waitn(HALF);
   endtask

   task automatic desel();
      waitn(HALF); cs_n = 1'b1; waitn(3 * HALF);
   endtask

   task automatic xfer_bits(input int nbits, input logic [7:0] dout,
                            input bit pulse, output logic [7:0] din);
      din = '0;
      for (int b = 7; b > 7 - nbits; b--) begin
         mosi = dout[b];
         waitn(HALF);
         din[b] = miso;
         sck = 1'b1;
         if (pulse && b == 0) begin
            waitn(2); op_done = 1'b1; waitn(1); op_done = 1'b0; waitn(HALF - 3);
         end else begin
            waitn(HALF);
         end
         sck = 1'b0;
      end
   endtask

   task automatic send(input logic [7:0] v);
      logic [7:0] dummy;
      xfer_bits(8, v, 1'b0, dummy);
   endtask

   task automatic recv(output logic [7:0] v);
      xfer_bits(8, 8'h00, 1'b0, v);
   endtask

   task automatic cmd1(input logic [7:0] v);
      sel(); send(v); desel();
   endtask

   task automatic read_status(output logic [7:0] v);
      sel(); send(8'h05); recv(v); desel();
   endtask

   task automatic t_reset();
      chk("R1 wel", wel, 0); chk("R1 srwd", srwd, 0);
      chk("R1 prot", prot, 0); chk("R1 addr4", addr4, 0);
      chk("R1 miso", miso, 0);
   endtask

   task automatic t_wren_wrdi();
      logic [7:0] a, b;
      cmd1(8'h06);
      chk("R2 wren", wel, 1);
      sel(); send(8'h05); recv(a); recv(b); desel();
      chk("R3 status wel", a, 8'h02);
      chk("R3 repeat", b, 8'h02);
      chk("R3 idle miso", miso, 0);
      cmd1(8'h04);
      chk("R2 wrdi", wel, 0);
      read_status(a);
      chk("R3 status clear", a, 8'h00);
   endtask

   task automatic t_multi();
      sel(); send(8'h06); send(8'h05); recv(rd); desel();
      chk("R9 chained", rd, 8'h02);
      cmd1(8'h04);
   endtask

   task automatic t_wrsr();
      sel(); send(8'h06); send(8'h01); send(8'h8C); send(8'h05); recv(rd); desel();
      chk("R4 status", rd, 8'h8C);
      chk("R4 srwd", srwd, 1); chk("R4 prot", prot, 5'h03); chk("R4 wel", wel, 0);
   endtask

   task automatic t_no_wel();
      sel(); send(8'h01); send(8'h00); desel();
      chk("R5 srwd", srwd, 1); chk("R5 prot", prot, 5'h03);
   endtask

   task automatic t_protect();
      wp_n = 1'b0; waitn(8);
      sel(); send(8'h06); send(8'h01); send(8'h00); desel();
      chk("R6 refused srwd", srwd, 1); chk("R6 refused prot", prot, 5'h03);
      chk("R6 wel kept", wel, 1);
      wp_n = 1'b1; waitn(8);
      sel(); send(8'h01); send(8'h00); desel();
      chk("R6 wp high srwd", srwd, 0); chk("R6 wp high prot", prot, 0);
      wp_n = 1'b0; waitn(8);
      sel(); send(8'h06); send(8'h01); send(8'h90); desel();
      chk("R6 unlocked srwd", srwd, 1); chk("R6 unlocked prot", prot, 5'h04);
      wp_n = 1'b1; waitn(8);
   endtask

   task automatic t_addr4();
      cmd1(8'hB7);
      chk("R7 addr4", addr4, 1);
   endtask

   task automatic t_soft_reset();
      sel(); send(8'h06); send(8'h01); send(8'h84); send(8'h06); desel();
      cmd1(8'h99);
      chk("R8 lone fire wel", wel, 1); chk("R8 lone fire addr4", addr4, 1);
      sel(); send(8'h66); send(8'h06); send(8'h99); desel();
      chk("R8 broken pair wel", wel, 1);
      sel(); send(8'h66); send(8'h99); desel();
      chk("R8 wel", wel, 0); chk("R8 addr4", addr4, 0);
      chk("R8 srwd kept", srwd, 1); chk("R8 prot kept", prot, 5'h01);
   endtask

   task automatic t_done();
      logic [7:0] dummy;
      cmd1(8'h06);
      @(negedge clk); op_done = 1'b1; @(negedge clk); op_done = 1'b0; waitn(2);
      chk("R10 done clears", wel, 0);
      sel(); xfer_bits(8, 8'h06, 1'b1, dummy); desel();
      chk("R10 collision", wel, 1);
      cmd1(8'h04);
   endtask

   task automatic t_abort();
      logic [7:0] dummy;
      sel(); xfer_bits(4, 8'hF0, 1'b0, dummy); desel();
      cmd1(8'h06);
      chk("R11 fresh frame", wel, 1);
      cmd1(8'h04);
   endtask

   initial begin
      fork
         begin
            waitn(200000 - 10);
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
         end
      join_none
      waitn(5); rst_n = 1'b1; waitn(5);
      t_reset();
      t_wren_wrdi();
      t_multi();
      t_wrsr();
      t_no_wel();
      t_protect();
      t_addr4();
      t_soft_reset();
      t_done();
      t_abort();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule